// File: doc/BRIEF.md
# Two-Byte-Per-Clock RC4 Keystream Generator

This block produces the RC4 keystream two bytes at a time. A key scheduler elsewhere builds the 256-entry permutation and hands it over in one wide load. From then on, every enabled clock advances the generator by two RC4 rounds. The first stage unrolls the two rounds. It moves the index forward by two, forms both new `j` values, applies both swaps to the register state, and works out where each output byte will be read. The second stage reads both bytes from the state after both swaps and presents them as a pair. The earlier byte of the pair is on `byteA`.

Unrolling the rounds brings in two hazards, and the first stage handles both. The second round's `j` must see the value that the first swap wrote. The first byte must come from the state as it stood after the first swap only. The stage handles this by mapping that byte's read address through the second swap, so the byte read later from the final state is the correct one. The block relies on the fact that a swap leaves the sum of the two swapped entries unchanged, which lets both read addresses be fixed in the first stage. `enable` stalls both stages together. A load restarts the stream with `i = j = 0` and drops any pair still in flight.

Top module: `ks_pair_gen`

## Requirements
- R1: Each enabled iteration advances the index `i` by two. `byteA` and `byteB` equal the next two bytes of the standard RC4 keystream, in that order.
- R2: `byteA` equals the RC4 output taken from the state after the first swap only. This holds even when the second swap moves the entry at that byte's read address.
- R3: When the second round's index `i+2` equals the first round's `j`, the second `j` uses the value written by the first swap.
- R4: The state after both swaps and both indices feed back to stage one. While `enable` stays high, a new valid pair appears on every clock.
- R5: After a load, the first `pairValid` appears on the second enabled rising edge. It is not present on the first.
- R6: `loadStrobe` copies `loadState` into the state, with entry k held at bits [8k+7:8k]. It sets `i = j = 0` and clears both pipeline valid bits, so no pair from before the load is presented. The load takes priority over `enable`.
- R7: While `enable` is low, nothing advances. `pairValid` is 0 on the following cycles, `byteA` and `byteB` hold their values, and the stream later resumes with no byte skipped.
- R8: After reset, `pairValid`, `byteA` and `byteB` are 0. No pair is produced until a load has happened, whatever `enable` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadStrobe | input | 1 | Load the scheduled state and restart the stream |
| loadState | input | 2048 | Scheduled permutation; entry k at bits [8k+7:8k] |
| enable | input | 1 | Advance both pipeline stages |
| byteA | output | 8 | Earlier keystream byte of the pair |
| byteB | output | 8 | Later keystream byte of the pair |
| pairValid | output | 1 | A new pair is on byteA/byteB this cycle |

## Verification
The hardest cases to reach from the ports are the two unrolling hazards. One is the first byte's read address hitting an entry that the second swap moves. The other is `i+2` landing on the first `j`. Both depend on the running state and not on any input. The first-`j` hazard is forced from the very first iteration by loading a permutation whose entry 1 holds 2. The address hazard is reached by a long run from a key-scheduled permutation, where it occurs every few hundred bytes. A reference model in the bench counts how often each hazard occurs and attributes each compared pair to the hazard it covered. A stall, and a reload while the pipeline is full, are applied mid-stream to show that the feedback path and the flush keep the sequence exact.

// File: rtl/ks_pkg.sv
package ks_pkg;
  // Strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic load;     // copy in a new state, zero indices
    logic advance;  // move stage one and stage two forward
    logic capture;  // stage two samples the state into the output bytes
  } ksStrobe_t;
endpackage

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import ks_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      loadStrobe,
  input  logic      enable,
  output ksStrobe_t strobe,
  output logic      pairValid
);
  logic primed;   // a state has been loaded since reset
  logic s1Valid;  // stage one holds a pending pair

  always_comb begin
    strobe.load    = loadStrobe;
    strobe.advance = enable && primed && !loadStrobe;
    strobe.capture = enable && primed && !loadStrobe && s1Valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      s1Valid   <= 1'b0;
      pairValid <= 1'b0;
    end else if (loadStrobe) begin
      primed    <= 1'b1;
      s1Valid   <= 1'b0;
      pairValid <= 1'b0;
    end else begin
      if (strobe.advance) s1Valid <= 1'b1;
      pairValid <= strobe.capture;
    end
  end

  // R6: a load empties both stages
  p_flush_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loadStrobe |=> (!pairValid && !s1Valid));
  // R7: a stalled cycle presents no new pair
  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pairValid);
  // R8: nothing is pending before the first load
  p_unprimed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (!s1Valid && !pairValid));
  // R5: a pair never reaches the output without passing stage one
  p_two_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |-> $past(s1Valid));
endmodule

// File: rtl/ks_datapath.sv
module ks_datapath
  import ks_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ksStrobe_t                         strobe,
  input  logic [(1<<IDX_W)*IDX_W-1:0]       loadState,
  output logic [IDX_W-1:0]                  byteA,
  output logic [IDX_W-1:0]                  byteB
);
  localparam int ENTRIES = 1 << IDX_W;
  typedef logic [IDX_W-1:0] idx_t;

  idx_t sArr [ENTRIES];
  idx_t iIdx, jIdx;
  idx_t z1Reg, z2Reg;

  // ---- stage one: two unrolled rounds ----
  idx_t i1, i2, j1, j2;
  idx_t valA, valB, valC, valD;
  idx_t z1Raw, z1Eff, z2Addr;

  always_comb begin
    i1   = iIdx + IDX_W'(1);
    i2   = iIdx + IDX_W'(2);
    valA = sArr[i1];
    j1   = jIdx + valA;
    valB = sArr[j1];
    // R3: entry i2 as left by the first swap (i2 never equals i1)
    valC = (i2 == j1) ? valA : sArr[i2];
    j2   = j1 + valC;
    // entry j2 as left by the first swap
    if (j2 == j1)      valD = valA;
    else if (j2 == i1) valD = valB;
    else               valD = sArr[j2];
    z1Raw  = valA + valB;
    z2Addr = valC + valD;
    // R2: map byte A's address back through the second swap
    if (z1Raw == i2)      z1Eff = j2;
    else if (z1Raw == j2) z1Eff = i2;
    else                  z1Eff = z1Raw;
  end

  // State after both swaps; later writes take priority
  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    localparam idx_t KI = IDX_W'(k);
    idx_t nextVal;
    always_comb begin
      if (KI == j2)      nextVal = valC;
      else if (KI == i2) nextVal = valD;
      else if (KI == j1) nextVal = valA;
      else if (KI == i1) nextVal = valB;
      else               nextVal = sArr[k];
    end
    always_ff @(posedge clk) begin
      if (strobe.load)         sArr[k] <= loadState[k*IDX_W +: IDX_W];
      else if (strobe.advance) sArr[k] <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iIdx  <= '0;
      jIdx  <= '0;
      z1Reg <= '0;
      z2Reg <= '0;
    end else if (strobe.load) begin
      iIdx <= '0;
      jIdx <= '0;
    end else if (strobe.advance) begin
      iIdx  <= i2;
      jIdx  <= j2;
      z1Reg <= z1Eff;
      z2Reg <= z2Addr;
    end
  end

  // ---- stage two: read both bytes from the post-swap state ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byteA <= '0;
      byteB <= '0;
    end else if (strobe.capture) begin
      byteA <= sArr[z1Reg];
      byteB <= sArr[z2Reg];
    end
  end

  // R1: each iteration steps i by two
  p_i_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |=> (iIdx == $past(iIdx) + IDX_W'(2)));
  // R6: a load restarts both indices at zero
  p_load_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> (iIdx == '0 && jIdx == '0));
  // R7: a stall leaves indices and output bytes unchanged
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.advance && !strobe.load) |=>
      ($stable(iIdx) && $stable(jIdx) && $stable(byteA) && $stable(byteB)));
  // R2: the remapped address is one of the raw address or the second swap's pair
  p_fixup_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance |-> (z1Eff == z1Raw || z1Eff == i2 || z1Eff == j2));
endmodule

// File: rtl/ks_pair_gen.sv
module ks_pair_gen
  import ks_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        loadStrobe,
  input  logic [(1<<IDX_W)*IDX_W-1:0] loadState,
  input  logic                        enable,
  output logic [IDX_W-1:0]            byteA,
  output logic [IDX_W-1:0]            byteB,
  output logic                        pairValid
);
  ksStrobe_t strobe;

  ks_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .loadStrobe (loadStrobe),
    .enable     (enable),
    .strobe     (strobe),
    .pairValid  (pairValid)
  );

  ks_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .loadState (loadState),
    .byteA     (byteA),
    .byteB     (byteB)
  );
endmodule

// File: tb/ks_pair_gen_bench.sv
module ks_pair_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         loadStrobe = 1'b0;
  logic [2047:0] loadState = '0;
  logic         enable = 1'b0;
  logic [7:0]   byteA, byteB;
  logic         pairValid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int hitFix = 0;   // model: byte A address touched by second swap
  int hitFwd = 0;   // model: i+2 equal to first j

  logic [7:0] refS [256];
  logic [7:0] refI, refJ;
  logic [7:0] stS  [256];

  ks_pair_gen u_ks_pair_gen (
    .clk(clk), .rst_n(rst_n), .loadStrobe(loadStrobe), .loadState(loadState),
    .enable(enable), .byteA(byteA), .byteB(byteB), .pairValid(pairValid)
  );

  always #4 clk = ~clk;  // 125 MHz

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // reference RC4 step; reports which hazards this round pair hits
  task automatic ref_pair(output logic [7:0] zA, output logic [7:0] zB,
                          output bit fix, output bit fwd);
    logic [7:0] t, i1, j1, i2, j2, za;
    i1 = refI + 8'd1; j1 = refJ + refS[i1];
    t = refS[i1]; refS[i1] = refS[j1]; refS[j1] = t;
    za = refS[i1] + refS[j1]; zA = refS[za];
    i2 = i1 + 8'd1; fwd = (i2 == j1);
    j2 = j1 + refS[i2];
    t = refS[i2]; refS[i2] = refS[j2]; refS[j2] = t;
    fix = (za == i2 || za == j2) && (i2 != j2);
    zB = refS[8'(refS[i2] + refS[j2])];
    refI = i2; refJ = j2;
  endtask

  function automatic logic [2047:0] pack_state();
    logic [2047:0] v;
    for (int k = 0; k < 256; k++) v[k*8 +: 8] = stS[k];
    return v;
  endfunction

  task automatic make_identity();
    for (int k = 0; k < 256; k++) stS[k] = 8'(k);
  endtask

  task automatic make_scheduled(input int seed);
    logic [7:0] jj, t;
    make_identity();
    jj = 0;
    for (int k = 0; k < 256; k++) begin
      jj = jj + stS[k] + 8'((k % 7) * 37 + seed);
      t = stS[k]; stS[k] = stS[jj]; stS[jj] = t;
    end
  endtask

  // load stS with enable low; model restarts at i=j=0
  task automatic do_load();
    @(negedge clk);
    loadState = pack_state(); loadStrobe = 1'b1;
    for (int k = 0; k < 256; k++) refS[k] = stS[k];
    refI = 0; refJ = 0;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  // run with enable high until n pairs compared, one per clock (R4)
  task automatic run_pairs(input int n, input bit firstCheck);
    logic [7:0] ea, eb; bit fix, fwd; int got; string tag;
    got = 0;
    enable = 1'b1;
    if (firstCheck) begin
      @(negedge clk);
      check("R5 no pair after first enabled edge", pairValid, 0);
      @(negedge clk);
      check("R5 pair after second enabled edge", pairValid, 1);
    end else begin
      @(negedge clk);
    end
    while (got < n) begin
      check("R4 valid every enabled cycle", pairValid, 1);
      ref_pair(ea, eb, fix, fwd);
      if (fix) hitFix++;
      if (fwd) hitFwd++;
      tag = fix ? "R2" : (fwd ? "R3" : "R1");
      check({tag, " byteA"}, byteA, ea);
      check({tag, " byteB"}, byteB, eb);
      got++;
      if (got < n) @(negedge clk);
    end
  endtask

  task automatic t_reset_and_unprimed();
    check("R8 reset pairValid", pairValid, 0);
    check("R8 reset byteA", byteA, 0);
    check("R8 reset byteB", byteB, 0);
    enable = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R8 no pair without load", pairValid, 0);
    end
    enable = 1'b0;
  endtask

  task automatic t_identity();
    make_identity(); do_load();
    run_pairs(64, 1'b1);
    enable = 1'b0;
  endtask

  task automatic t_forward();
    make_identity(); stS[1] = 8'd2; stS[2] = 8'd1;
    do_load();
    run_pairs(32, 1'b1);
    enable = 1'b0;
    check("R3 forward case reached", hitFwd > 0, 1);
  endtask

  task automatic t_long_and_stall();
    logic [7:0] holdA, holdB;
    make_scheduled(11); do_load();
    run_pairs(600, 1'b1);
    holdA = byteA; holdB = byteB;
    enable = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R7 no pair while stalled", pairValid, 0);
      check("R7 byteA held", byteA, holdA);
      check("R7 byteB held", byteB, holdB);
    end
    run_pairs(300, 1'b0);
    check("R2 fixup case reached", hitFix > 0, 1);
  endtask

  task automatic t_reload_full();
    // pipeline is full with enable high; load takes priority
    make_scheduled(91);
    loadState = pack_state(); loadStrobe = 1'b1;
    for (int k = 0; k < 256; k++) refS[k] = stS[k];
    refI = 0; refJ = 0;
    @(negedge clk);
    check("R6 flushed on load", pairValid, 0);
    loadStrobe = 1'b0;
    run_pairs(200, 1'b1);
    enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_unprimed();
    t_identity();
    t_forward();
    t_long_and_stall();
    t_reload_full();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule